// File: doc/BRIEF.md
# Two-Read One-Write Memory with XOR Parity Reconstruction

This block is a small multiport scratchpad offering two independent read ports and one write port, all served every clock with no stall and no back-pressure. The logical address space is divided between two data banks, each of which only ever needs one direct read per cycle. A third bank holds, at each offset, the bitwise XOR of the two data banks at that offset.

Read port 0 is always served directly from the bank it addresses. When read port 1 addresses the same data bank, it cannot use that bank's single read port. It instead rebuilds its word by XOR-ing the other data bank and the parity bank at its offset. Each write stores the new word in its data bank and rewrites the parity word from the new data and the other bank's current word at the same offset, using an internal read port reserved for that purpose.

Top module: `xor_dual_read_mem`

## Requirements
- R1: The most significant address bit selects the data bank (0: lower bank, 1: upper bank), and the remaining bits give the offset within that bank. Every one of the 2^ADDR_W addresses holds its own word.
- R2: After a write to offset i completes, the parity bank word at i equals the XOR of both data bank words at i.
- R3: Read data appears on both ports on the clock edge after the address is presented, with one cycle of latency on both ports.
- R4: When both read addresses select the same data bank, read port 1 returns the word stored at its address, which it rebuilds from the other data bank and the parity bank.
- R5: Two reads of the same address in the same cycle return identical data on both ports.
- R6: A read of the address being written in the same cycle returns the word stored before that write.
- R7: Reset (rst_n low) clears every stored word to zero and drives both read data outputs to zero.
- R8: While wr_en is low, wr_addr and wr_data have no effect on any stored word.
- R9: A new pair of reads and a write are accepted on every cycle, back to back, including cycles with a bank collision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| rd0_addr | input | ADDR_W | Read port 0 address |
| rd0_data | output | DATA_W | Read port 0 data, valid one cycle after the address |
| rd1_addr | input | ADDR_W | Read port 1 address |
| rd1_data | output | DATA_W | Read port 1 data, valid one cycle after the address |
| wr_en | input | 1 | Write enable |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |

## Verification
The assertions assume that every stored word starts from a known value, because both the parity invariant and the reconstruction check compare bank contents. The reset clears all three banks, and the stimulus applies reset before any access, so no unknown word is ever folded into a parity comparison. Apart from that, the assertions place no limit on the inputs. The random traffic therefore chooses read addresses freely, steering port 1 into port 0's bank most of the time so that reconstruction is exercised heavily, and it lets writes land on addresses being read in the same cycle.

// File: rtl/xor_dual_read_mem.sv
module xor_dual_read_mem #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd0_addr,
  output logic [DATA_W-1:0] rd0_data,
  input  logic [ADDR_W-1:0] rd1_addr,
  output logic [DATA_W-1:0] rd1_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data
);
  localparam int OFF_W = ADDR_W - 1;
  localparam int DEPTH = 1 << OFF_W;

  logic [DATA_W-1:0] lo_q  [DEPTH];
  logic [DATA_W-1:0] hi_q  [DEPTH];
  logic [DATA_W-1:0] par_q [DEPTH];

  logic             sel0, sel1, wsel, clash;
  logic [OFF_W-1:0] off0, off1, woff;
  logic [DATA_W-1:0] direct0, direct1, rebuilt1, wr_other;

  assign sel0 = rd0_addr[ADDR_W-1];
  assign sel1 = rd1_addr[ADDR_W-1];
  assign wsel = wr_addr[ADDR_W-1];
  assign off0 = rd0_addr[OFF_W-1:0];
  assign off1 = rd1_addr[OFF_W-1:0];
  assign woff = wr_addr[OFF_W-1:0];

  assign clash    = (sel0 == sel1);
  assign direct0  = sel0 ? hi_q[off0] : lo_q[off0];
  assign direct1  = sel1 ? hi_q[off1] : lo_q[off1];
  assign rebuilt1 = (sel1 ? lo_q[off1] : hi_q[off1]) ^ par_q[off1];
  assign wr_other = wsel ? lo_q[woff] : hi_q[woff];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd0_data <= '0;
      rd1_data <= '0;
      for (int k = 0; k < DEPTH; k++) begin
        lo_q[k]  <= '0;
        hi_q[k]  <= '0;
        par_q[k] <= '0;
      end
    end else begin
      rd0_data <= direct0;
      rd1_data <= clash ? rebuilt1 : direct1;
      if (wr_en) begin
        if (wsel) hi_q[woff] <= wr_data;
        else      lo_q[woff] <= wr_data;
        par_q[woff] <= wr_data ^ wr_other;
      end
    end
  end

  assert_parity_kept_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (par_q[$past(woff)] == (lo_q[$past(woff)] ^ hi_q[$past(woff)])));

  assert_rebuild_matches_R4: assert property (@(posedge clk) disable iff (!rst_n)
    clash |-> (rebuilt1 == direct1));

  assert_same_addr_equal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rd0_addr == rd1_addr) |-> (rd0_data == rd1_data));

  assert_reset_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (rd0_data == '0 && rd1_data == '0));
endmodule

// File: tb/xor_dual_read_mem_test.sv
module xor_dual_read_mem_test;
  localparam int PERIOD = 10;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int NV = 10;

  typedef struct packed {
    logic          we;
    logic [AW-1:0] wa;
    logic [DW-1:0] wd;
    logic [AW-1:0] ra;
    logic [AW-1:0] rb;
    logic [DW-1:0] ea;
    logic [DW-1:0] eb;
  } vec_t;

  // Expected values are the words stored before the write in the same row.
  localparam vec_t TBL [NV] = '{
    '{1'b1, 6'd3,  16'h1111, 6'd3,  6'd35, 16'h0000, 16'h0000},
    '{1'b1, 6'd35, 16'h2222, 6'd3,  6'd35, 16'h1111, 16'h0000},
    '{1'b0, 6'd0,  16'h0000, 6'd3,  6'd35, 16'h1111, 16'h2222},
    '{1'b1, 6'd4,  16'hABCD, 6'd3,  6'd5,  16'h1111, 16'h0000},
    '{1'b0, 6'd0,  16'h0000, 6'd35, 6'd3,  16'h2222, 16'h1111},
    '{1'b0, 6'd0,  16'h0000, 6'd3,  6'd3,  16'h1111, 16'h1111},
    '{1'b0, 6'd3,  16'hFFFF, 6'd3,  6'd4,  16'h1111, 16'hABCD},
    '{1'b0, 6'd0,  16'h0000, 6'd3,  6'd35, 16'h1111, 16'h2222},
    '{1'b1, 6'd36, 16'h5A5A, 6'd36, 6'd4,  16'h0000, 16'hABCD},
    '{1'b0, 6'd0,  16'h0000, 6'd36, 6'd36, 16'h5A5A, 16'h5A5A}
  };

  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [AW-1:0] rd0_addr = '0, rd1_addr = '0, wr_addr = '0;
  logic [DW-1:0] wr_data = '0, rd0_data, rd1_data;

  int checks = 0, fails = 0;
  logic pend = 0;
  logic [DW-1:0] pa, pb;
  string ptag;
  logic [DW-1:0] model [1 << AW];

  always #(PERIOD/2) clk = ~clk;

  xor_dual_read_mem #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .rd0_addr(rd0_addr), .rd0_data(rd0_data),
    .rd1_addr(rd1_addr), .rd1_data(rd1_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

  task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(logic we, logic [AW-1:0] wa, logic [DW-1:0] wd,
                       logic [AW-1:0] ra, logic [AW-1:0] rb,
                       logic [DW-1:0] ea, logic [DW-1:0] eb, string tag);
    @(negedge clk);
    if (pend) begin
      check({ptag, " port0"}, rd0_data, pa);
      check({ptag, " port1"}, rd1_data, pb);
    end
    wr_en = we; wr_addr = wa; wr_data = wd; rd0_addr = ra; rd1_addr = rb;
    pa = ea; pb = eb; ptag = tag; pend = 1;
    if (we) model[wa] = wd;
  endtask

  initial begin
    for (int k = 0; k < (1 << AW); k++) model[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R7 reset port0", rd0_data, '0);
    check("R7 reset port1", rd1_data, '0);

    for (int i = 0; i < NV; i++)
      apply(TBL[i].we, TBL[i].wa, TBL[i].wd, TBL[i].ra, TBL[i].rb,
            TBL[i].ea, TBL[i].eb, $sformatf("R1 R3 R4 R5 R6 R8 row %0d", i));

    // Random traffic: port 1 mostly forced into port 0's bank (R4, R9).
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] a, b, w;
      logic we;
      a  = AW'($urandom);
      b  = AW'($urandom);
      w  = AW'($urandom);
      we = $urandom_range(0, 2) != 0;
      if ($urandom_range(0, 9) < 7) b[AW-1] = a[AW-1];
      if ($urandom_range(0, 7) == 0) w = a;
      if ($urandom_range(0, 9) == 0) b = a;
      apply(we, w, DW'($urandom), a, b, model[a], model[b], "R2 R4 R6 R9 random");
    end
    apply(1'b0, '0, '0, '0, '0, model[0], model[0], "R5 final");
    @(negedge clk);
    check("R5 final port0", rd0_data, model[0]);
    check("R5 final port1", rd1_data, model[0]);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(PERIOD * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule